// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block keeps the indices of three circular descriptor rings: a request ring filled by software, a completion ring filled by the device, and a message ring for device events. Each ring lives in a set of 4 KiB memory pages that need not be contiguous. The block turns a free-running ring pointer into the physical address of one descriptor slot. It does not read descriptors and does not move data. It only produces addresses and index updates.

Software configures the data rings (request and completion together) and then the message ring. Each setup carries a page count and a list of page frame numbers. The block derives each ring's index mask from the page count and keeps an internal consume pointer (request) and fill pointers (completion, message). It offers pop and flush strobes and a message-room flag. The index words shared with software (producer, consumer and log2 size of each ring) sit in a small word-addressed store. Software reads and writes that store through a register-style port, and the block updates it on setup and flush.

Top module: `paged_ring_indexer`

## Requirements
- R1: A data setup is accepted when both page counts lie in 1..MAX_PAGES. On acceptance, at the clock edge that samples the strobe: cfgDone=1 and cfgOk=1; shared words 0, 1, 3 and 4 become 0; words 2 and 5 become L = bit length of (pages × entries per page − 1) for the request and completion rings; and that ring's index mask becomes 2^L − 1.
- R2: A data setup with a page count of 0 or above MAX_PAGES gives cfgDone=1 and cfgOk=0. It changes no mask, pointer, page table, shared word or valid flag.
- R3: reqReady is 1 only when the data rings are valid and shared word 0 (request producer) differs from the internal consume pointer. While reqReady is 0, reqDescAddr is 0 and reqPop has no effect.
- R4: A descriptor address is computed from the masked index i = pointer AND mask. The page is page table entry (i / entries per page), shifted left by 12. To that base the block adds (i mod entries per page) × descriptor size. Page table entries at or above the configured count hold 0.
- R5: An accepted reqPop adds one to the consume pointer, a free-running 32-bit count, so the masked index wraps.
- R6: cmpPop adds one to the completion fill pointer whenever the data rings are valid, with no overflow check. msgPop adds one to the message fill pointer whenever the message ring is valid, whatever msgRoom says.
- R7: msgRoom = message ring valid AND ((word 6 − word 7) mod 2^32) < mask + 1.
- R8: A message setup is accepted only when the data rings are valid and the page count lies in 1..MSG_MAX_PAGES. On acceptance, words 6 and 7 become 0, word 8 becomes its log2 size, and the fill pointer becomes 0. Otherwise cfgOk=0 and nothing changes.
- R9: reqFlush writes the consume pointer to word 1. cmpFlush writes the completion fill pointer to word 3. msgFlush writes the message fill pointer to word 6.
- R10: wipe clears all masks, pointers, page tables and both valid flags. The shared words are left as they are. Afterwards reqReady, msgRoom and all three addresses are 0.
- R11: The shared store has words 0..8: req producer, req consumer, req log2, cmp producer, cmp consumer, cmp log2, msg producer, msg consumer, msg log2. A host write shows on shRdData after the next edge. Addresses 9..15 read as 0. When the block writes the same word in the same cycle, the block's value wins.
- R12: After reset, all shared words, addresses, reqReady, msgRoom and cfgDone are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgData | input | 1 | Data ring setup strobe |
| cfgMsg | input | 1 | Message ring setup strobe |
| reqPageCnt | input | CNT_W | Request ring page count |
| cmpPageCnt | input | CNT_W | Completion ring page count |
| msgPageCnt | input | CNT_W | Message ring page count |
| reqPfnList | input | MAX_PAGES*PFN_W | Request page frame numbers, entry 0 in the low bits |
| cmpPfnList | input | MAX_PAGES*PFN_W | Completion page frame numbers |
| msgPfnList | input | MSG_MAX_PAGES*PFN_W | Message page frame numbers |
| cfgDone | output | 1 | A setup was sampled at the last edge |
| cfgOk | output | 1 | That setup was accepted |
| wipe | input | 1 | Clear all ring state |
| reqPop | input | 1 | Consume one request descriptor |
| reqFlush | input | 1 | Publish the consume pointer |
| reqReady | output | 1 | A request descriptor is pending |
| reqDescAddr | output | PFN_W+12 | Address of the next request descriptor |
| cmpPop | input | 1 | Claim one completion slot |
| cmpFlush | input | 1 | Publish the completion fill pointer |
| cmpDescAddr | output | PFN_W+12 | Address of the next completion slot |
| msgPop | input | 1 | Claim one message slot |
| msgFlush | input | 1 | Publish the message fill pointer |
| msgRoom | output | 1 | The message ring has a free slot |
| msgDescAddr | output | PFN_W+12 | Address of the next message slot |
| shWrEn | input | 1 | Shared store write enable |
| shAddr | input | 4 | Shared store word address |
| shWrData | input | 32 | Shared store write data |
| shRdData | output | 32 | Shared store read data |

## Verification
The bench sets four entries per page on every ring, up to four data pages and two message pages, and 20-bit frame numbers. With four entries per page, a handful of pops crosses page boundaries and wraps the masked index. A three-page request ring gives a mask of 15, so indices 12..15 select a page slot beyond the configured count, which must read as a zero base. The small message ring also brings the room comparison to its full and wrapped-around edges with only a few shared-word writes.

// File: rtl/paged_ring_pkg.sv
package paged_ring_pkg;

  localparam int PAGE_SHIFT = 12;
  localparam int SH_WORDS   = 9;

  // Shared word map; the order is visible to software
  typedef enum logic [3:0] {
    SH_REQ_PROD = 4'd0, SH_REQ_CONS = 4'd1, SH_REQ_LOG2 = 4'd2,
    SH_CMP_PROD = 4'd3, SH_CMP_CONS = 4'd4, SH_CMP_LOG2 = 4'd5,
    SH_MSG_PROD = 4'd6, SH_MSG_CONS = 4'd7, SH_MSG_LOG2 = 4'd8
  } shSel_e;

  typedef struct packed {
    logic wipe;
    logic loadData;
    logic loadMsg;
    logic advReq;
    logic advCmp;
    logic advMsg;
    logic pubReq;
    logic pubCmp;
    logic pubMsg;
  } ringCtl_t;

  // Number of significant bits in v
  function automatic logic [5:0] bitLen(input logic [31:0] v);
    logic [5:0] n;
    n = '0;
    for (int b = 0; b < 32; b++) begin
      if (v[b]) n = 6'(b + 1);
    end
    return n;
  endfunction

  function automatic logic [31:0] maskOf(input logic [5:0] len);
    logic [63:0] one;
    one = 64'd1;
    return 32'((one << len) - 64'd1);
  endfunction

endpackage

// File: rtl/paged_ring_ctrl.sv
module paged_ring_ctrl
  import paged_ring_pkg::*;
#(
  parameter int MAX_PAGES     = 4,
  parameter int MSG_MAX_PAGES = 2,
  parameter int CNT_W         = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgData,
  input  logic             cfgMsg,
  input  logic [CNT_W-1:0] reqPageCnt,
  input  logic [CNT_W-1:0] cmpPageCnt,
  input  logic [CNT_W-1:0] msgPageCnt,
  input  logic             wipe,
  input  logic             reqPop,
  input  logic             cmpPop,
  input  logic             msgPop,
  input  logic             reqFlush,
  input  logic             cmpFlush,
  input  logic             msgFlush,
  input  logic             reqHasWork,
  output ringCtl_t         ctl,
  output logic             dataValid,
  output logic             msgValid,
  output logic             cfgDone,
  output logic             cfgOk
);

  logic dataCntOk, msgCntOk;

  assign dataCntOk = (reqPageCnt != '0) && (reqPageCnt <= CNT_W'(MAX_PAGES)) &&
                     (cmpPageCnt != '0) && (cmpPageCnt <= CNT_W'(MAX_PAGES));
  assign msgCntOk  = (msgPageCnt != '0) && (msgPageCnt <= CNT_W'(MSG_MAX_PAGES));

  always_comb begin
    ctl          = '0;
    ctl.wipe     = wipe;
    ctl.loadData = cfgData && dataCntOk && !wipe;
    ctl.loadMsg  = cfgMsg && msgCntOk && dataValid && !wipe;
    ctl.advReq   = reqPop && dataValid && reqHasWork && !wipe && !ctl.loadData;
    ctl.advCmp   = cmpPop && dataValid && !wipe && !ctl.loadData;
    ctl.advMsg   = msgPop && msgValid && !wipe && !ctl.loadMsg;
    ctl.pubReq   = reqFlush && !wipe && !ctl.loadData;
    ctl.pubCmp   = cmpFlush && !wipe && !ctl.loadData;
    ctl.pubMsg   = msgFlush && !wipe && !ctl.loadMsg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataValid <= 1'b0;
      msgValid  <= 1'b0;
      cfgDone   <= 1'b0;
      cfgOk     <= 1'b0;
    end else begin
      if (wipe) begin
        dataValid <= 1'b0;
        msgValid  <= 1'b0;
      end else begin
        if (ctl.loadData) dataValid <= 1'b1;
        if (ctl.loadMsg)  msgValid  <= 1'b1;
      end
      cfgDone <= cfgData || cfgMsg;
      cfgOk   <= (cfgData || cfgMsg) && !wipe &&
                 (!cfgData || dataCntOk) &&
                 (!cfgMsg || (msgCntOk && dataValid));
    end
  end

  // R2
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgData && !cfgMsg && !dataCntOk && !wipe) |=> (dataValid == $past(dataValid)));

  // R8
  msg_needs_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(msgValid) |-> dataValid);

endmodule

// File: rtl/paged_ring_dpath.sv
module paged_ring_dpath
  import paged_ring_pkg::*;
#(
  parameter int PFN_W         = 20,
  parameter int MAX_PAGES     = 4,
  parameter int MSG_MAX_PAGES = 2,
  parameter int REQ_PER       = 32,
  parameter int CMP_PER       = 128,
  parameter int MSG_PER       = 64,
  parameter int REQ_DESC      = 128,
  parameter int CMP_DESC      = 32,
  parameter int MSG_DESC      = 64,
  parameter int CNT_W         = 8,
  localparam int ADDR_W       = PFN_W + PAGE_SHIFT
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  ringCtl_t                       ctl,
  input  logic                           dataValid,
  input  logic                           msgValid,
  input  logic [CNT_W-1:0]               reqPageCnt,
  input  logic [CNT_W-1:0]               cmpPageCnt,
  input  logic [CNT_W-1:0]               msgPageCnt,
  input  logic [MAX_PAGES*PFN_W-1:0]     reqPfnList,
  input  logic [MAX_PAGES*PFN_W-1:0]     cmpPfnList,
  input  logic [MSG_MAX_PAGES*PFN_W-1:0] msgPfnList,
  input  logic                           shWrEn,
  input  logic [3:0]                     shAddr,
  input  logic [31:0]                    shWrData,
  output logic [31:0]                    shRdData,
  output logic                           reqHasWork,
  output logic [ADDR_W-1:0]              reqDescAddr,
  output logic [ADDR_W-1:0]              cmpDescAddr,
  output logic [ADDR_W-1:0]              msgDescAddr,
  output logic                           msgRoom
);

  localparam int DPG_W     = (MAX_PAGES > 1) ? $clog2(MAX_PAGES) : 1;
  localparam int MPG_W     = (MSG_MAX_PAGES > 1) ? $clog2(MSG_MAX_PAGES) : 1;
  localparam int DSLOTS    = 1 << DPG_W;
  localparam int MSLOTS    = 1 << MPG_W;
  localparam int REQ_SH    = $clog2(REQ_PER);
  localparam int CMP_SH    = $clog2(CMP_PER);
  localparam int MSG_SH    = $clog2(MSG_PER);

  logic [31:0]      reqMask, cmpMask, msgMask;
  logic [31:0]      reqCons, cmpFill, msgFill;
  logic [PFN_W-1:0] reqTbl [DSLOTS];
  logic [PFN_W-1:0] cmpTbl [DSLOTS];
  logic [PFN_W-1:0] msgTbl [MSLOTS];
  logic [31:0]      shWord [SH_WORDS];

  logic [DSLOTS*PFN_W-1:0] reqPad, cmpPad;
  logic [MSLOTS*PFN_W-1:0] msgPad;
  logic [5:0]              reqLen, cmpLen, msgLen;

  assign reqPad = (DSLOTS*PFN_W)'(reqPfnList);
  assign cmpPad = (DSLOTS*PFN_W)'(cmpPfnList);
  assign msgPad = (MSLOTS*PFN_W)'(msgPfnList);
  assign reqLen = bitLen(32'(reqPageCnt) * 32'(REQ_PER) - 32'd1);
  assign cmpLen = bitLen(32'(cmpPageCnt) * 32'(CMP_PER) - 32'd1);
  assign msgLen = bitLen(32'(msgPageCnt) * 32'(MSG_PER) - 32'd1);

  // Ring masks, pointers and page tables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN || ctl.wipe) begin
      {reqMask, cmpMask, msgMask} <= '0;
      {reqCons, cmpFill, msgFill} <= '0;
      for (int i = 0; i < DSLOTS; i++) begin
        reqTbl[i] <= '0;
        cmpTbl[i] <= '0;
      end
      for (int i = 0; i < MSLOTS; i++) msgTbl[i] <= '0;
    end else begin
      if (ctl.loadData) begin
        reqMask <= maskOf(reqLen);
        cmpMask <= maskOf(cmpLen);
        reqCons <= '0;
        cmpFill <= '0;
        for (int i = 0; i < DSLOTS; i++) begin
          reqTbl[i] <= (i < int'(reqPageCnt)) ? reqPad[i*PFN_W +: PFN_W] : '0;
          cmpTbl[i] <= (i < int'(cmpPageCnt)) ? cmpPad[i*PFN_W +: PFN_W] : '0;
        end
      end else begin
        if (ctl.advReq) reqCons <= reqCons + 32'd1;
        if (ctl.advCmp) cmpFill <= cmpFill + 32'd1;
      end
      if (ctl.loadMsg) begin
        msgMask <= maskOf(msgLen);
        msgFill <= '0;
        for (int i = 0; i < MSLOTS; i++)
          msgTbl[i] <= (i < int'(msgPageCnt)) ? msgPad[i*PFN_W +: PFN_W] : '0;
      end else if (ctl.advMsg) begin
        msgFill <= msgFill + 32'd1;
      end
    end
  end

  // Shared index store; block updates are written last and so win
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < SH_WORDS; w++) shWord[w] <= '0;
    end else begin
      for (int w = 0; w < SH_WORDS; w++)
        if (shWrEn && shAddr == 4'(w)) shWord[w] <= shWrData;
      if (ctl.loadData) begin
        shWord[SH_REQ_PROD] <= '0;
        shWord[SH_REQ_CONS] <= '0;
        shWord[SH_REQ_LOG2] <= 32'(reqLen);
        shWord[SH_CMP_PROD] <= '0;
        shWord[SH_CMP_CONS] <= '0;
        shWord[SH_CMP_LOG2] <= 32'(cmpLen);
      end
      if (ctl.loadMsg) begin
        shWord[SH_MSG_PROD] <= '0;
        shWord[SH_MSG_CONS] <= '0;
        shWord[SH_MSG_LOG2] <= 32'(msgLen);
      end
      if (ctl.pubReq) shWord[SH_REQ_CONS] <= reqCons;
      if (ctl.pubCmp) shWord[SH_CMP_PROD] <= cmpFill;
      if (ctl.pubMsg) shWord[SH_MSG_PROD] <= msgFill;
    end
  end

  always_comb begin
    shRdData = '0;
    for (int w = 0; w < SH_WORDS; w++)
      if (shAddr == 4'(w)) shRdData = shWord[w];
  end

  // Slot address generation
  logic [31:0]       reqIdx, cmpIdx, msgIdx, msgGap;
  logic [DPG_W-1:0]  reqPg, cmpPg;
  logic [MPG_W-1:0]  msgPg;
  logic [ADDR_W-1:0] reqRaw, cmpRaw, msgRaw;

  assign reqIdx = reqCons & reqMask;
  assign cmpIdx = cmpFill & cmpMask;
  assign msgIdx = msgFill & msgMask;
  assign reqPg  = DPG_W'(reqIdx >> REQ_SH);
  assign cmpPg  = DPG_W'(cmpIdx >> CMP_SH);
  assign msgPg  = MPG_W'(msgIdx >> MSG_SH);
  assign reqRaw = {reqTbl[reqPg], {PAGE_SHIFT{1'b0}}} +
                  ADDR_W'(reqIdx & 32'(REQ_PER - 1)) * ADDR_W'(REQ_DESC);
  assign cmpRaw = {cmpTbl[cmpPg], {PAGE_SHIFT{1'b0}}} +
                  ADDR_W'(cmpIdx & 32'(CMP_PER - 1)) * ADDR_W'(CMP_DESC);
  assign msgRaw = {msgTbl[msgPg], {PAGE_SHIFT{1'b0}}} +
                  ADDR_W'(msgIdx & 32'(MSG_PER - 1)) * ADDR_W'(MSG_DESC);

  assign reqHasWork  = shWord[SH_REQ_PROD] != reqCons;
  assign reqDescAddr = (dataValid && reqHasWork) ? reqRaw : '0;
  assign cmpDescAddr = dataValid ? cmpRaw : '0;
  assign msgDescAddr = msgValid ? msgRaw : '0;
  assign msgGap      = shWord[SH_MSG_PROD] - shWord[SH_MSG_CONS];
  assign msgRoom     = msgValid && ({1'b0, msgGap} < ({1'b0, msgMask} + 33'd1));

  // R5
  req_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advReq |=> reqCons == $past(reqCons) + 32'd1);

  // R6
  cmp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advCmp |=> cmpFill == $past(cmpFill) + 32'd1);

  // R9
  req_publish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pubReq |=> shWord[SH_REQ_CONS] == $past(reqCons));

  // R8
  msg_setup_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadMsg |=> (msgFill == '0 && shWord[SH_MSG_PROD] == '0 &&
                     shWord[SH_MSG_CONS] == '0));

  // R10
  wipe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wipe |=> (reqMask == '0 && cmpMask == '0 && msgMask == '0 &&
                  reqCons == '0 && cmpFill == '0 && msgFill == '0));

endmodule

// File: rtl/paged_ring_indexer.sv
module paged_ring_indexer
  import paged_ring_pkg::*;
#(
  parameter int PFN_W         = 20,
  parameter int MAX_PAGES     = 4,
  parameter int MSG_MAX_PAGES = 2,
  parameter int REQ_PER       = 32,
  parameter int CMP_PER       = 128,
  parameter int MSG_PER       = 64,
  parameter int REQ_DESC      = 128,
  parameter int CMP_DESC      = 32,
  parameter int MSG_DESC      = 64,
  parameter int CNT_W         = 8,
  localparam int ADDR_W       = PFN_W + PAGE_SHIFT
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cfgData,
  input  logic                           cfgMsg,
  input  logic [CNT_W-1:0]               reqPageCnt,
  input  logic [CNT_W-1:0]               cmpPageCnt,
  input  logic [CNT_W-1:0]               msgPageCnt,
  input  logic [MAX_PAGES*PFN_W-1:0]     reqPfnList,
  input  logic [MAX_PAGES*PFN_W-1:0]     cmpPfnList,
  input  logic [MSG_MAX_PAGES*PFN_W-1:0] msgPfnList,
  output logic                           cfgDone,
  output logic                           cfgOk,
  input  logic                           wipe,
  input  logic                           reqPop,
  input  logic                           reqFlush,
  output logic                           reqReady,
  output logic [ADDR_W-1:0]              reqDescAddr,
  input  logic                           cmpPop,
  input  logic                           cmpFlush,
  output logic [ADDR_W-1:0]              cmpDescAddr,
  input  logic                           msgPop,
  input  logic                           msgFlush,
  output logic                           msgRoom,
  output logic [ADDR_W-1:0]              msgDescAddr,
  input  logic                           shWrEn,
  input  logic [3:0]                     shAddr,
  input  logic [31:0]                    shWrData,
  output logic [31:0]                    shRdData
);

  ringCtl_t ctl;
  logic     dataValid, msgValid, reqHasWork;

  paged_ring_ctrl #(
    .MAX_PAGES(MAX_PAGES), .MSG_MAX_PAGES(MSG_MAX_PAGES), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cfgData(cfgData), .cfgMsg(cfgMsg),
    .reqPageCnt(reqPageCnt), .cmpPageCnt(cmpPageCnt), .msgPageCnt(msgPageCnt),
    .wipe(wipe), .reqPop(reqPop), .cmpPop(cmpPop), .msgPop(msgPop),
    .reqFlush(reqFlush), .cmpFlush(cmpFlush), .msgFlush(msgFlush),
    .reqHasWork(reqHasWork), .ctl(ctl), .dataValid(dataValid),
    .msgValid(msgValid), .cfgDone(cfgDone), .cfgOk(cfgOk)
  );

  paged_ring_dpath #(
    .PFN_W(PFN_W), .MAX_PAGES(MAX_PAGES), .MSG_MAX_PAGES(MSG_MAX_PAGES),
    .REQ_PER(REQ_PER), .CMP_PER(CMP_PER), .MSG_PER(MSG_PER),
    .REQ_DESC(REQ_DESC), .CMP_DESC(CMP_DESC), .MSG_DESC(MSG_DESC), .CNT_W(CNT_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataValid(dataValid), .msgValid(msgValid),
    .reqPageCnt(reqPageCnt), .cmpPageCnt(cmpPageCnt), .msgPageCnt(msgPageCnt),
    .reqPfnList(reqPfnList), .cmpPfnList(cmpPfnList), .msgPfnList(msgPfnList),
    .shWrEn(shWrEn), .shAddr(shAddr), .shWrData(shWrData), .shRdData(shRdData),
    .reqHasWork(reqHasWork), .reqDescAddr(reqDescAddr),
    .cmpDescAddr(cmpDescAddr), .msgDescAddr(msgDescAddr), .msgRoom(msgRoom)
  );

  assign reqReady = dataValid && reqHasWork;

endmodule

// File: tb/paged_ring_indexer_test.sv
`timescale 1ns/1ps
module paged_ring_indexer_test;

  localparam int PFN_W = 20;
  localparam int MAXP  = 4;
  localparam int MSGP  = 2;
  localparam int PER   = 4;
  localparam int AW    = PFN_W + 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgData = 0, cfgMsg = 0, wipe = 0;
  logic [7:0] reqPageCnt = 0, cmpPageCnt = 0, msgPageCnt = 0;
  logic [MAXP*PFN_W-1:0] reqPfnList = {20'h44, 20'h33, 20'h22, 20'h11};
  logic [MAXP*PFN_W-1:0] cmpPfnList = {20'h99, 20'h88, 20'h66, 20'h55};
  logic [MSGP*PFN_W-1:0] msgPfnList = {20'h78, 20'h77};
  logic cfgDone, cfgOk, reqReady, msgRoom;
  logic reqPop = 0, reqFlush = 0, cmpPop = 0, cmpFlush = 0, msgPop = 0, msgFlush = 0;
  logic [AW-1:0] reqDescAddr, cmpDescAddr, msgDescAddr;
  logic shWrEn = 0;
  logic [3:0] shAddr = 0;
  logic [31:0] shWrData = 0, shRdData;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  paged_ring_indexer #(
    .PFN_W(PFN_W), .MAX_PAGES(MAXP), .MSG_MAX_PAGES(MSGP),
    .REQ_PER(PER), .CMP_PER(PER), .MSG_PER(PER)
  ) uut (
    .clk(clk), .rstN(rstN), .cfgData(cfgData), .cfgMsg(cfgMsg),
    .reqPageCnt(reqPageCnt), .cmpPageCnt(cmpPageCnt), .msgPageCnt(msgPageCnt),
    .reqPfnList(reqPfnList), .cmpPfnList(cmpPfnList), .msgPfnList(msgPfnList),
    .cfgDone(cfgDone), .cfgOk(cfgOk), .wipe(wipe),
    .reqPop(reqPop), .reqFlush(reqFlush), .reqReady(reqReady), .reqDescAddr(reqDescAddr),
    .cmpPop(cmpPop), .cmpFlush(cmpFlush), .cmpDescAddr(cmpDescAddr),
    .msgPop(msgPop), .msgFlush(msgFlush), .msgRoom(msgRoom), .msgDescAddr(msgDescAddr),
    .shWrEn(shWrEn), .shAddr(shAddr), .shWrData(shWrData), .shRdData(shRdData)
  );

  // Request ring vectors: producer value written, pops attempted, consume pointer expected
  localparam logic [31:0] VEC [5][3] = '{
    '{32'd3,  32'd2,  32'd2},
    '{32'd3,  32'd3,  32'd3},
    '{32'd17, 32'd14, 32'd17},
    '{32'd17, 32'd1,  32'd17},
    '{32'd20, 32'd1,  32'd18}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shWrite(input logic [3:0] a, input logic [31:0] d);
    shWrEn = 1'b1; shAddr = a; shWrData = d;
    tick();
    shWrEn = 1'b0;
  endtask

  task automatic shRead(input logic [3:0] a, output logic [31:0] d);
    shAddr = a;
    #1;
    d = shRdData;
  endtask

  // Address model from R4
  function automatic logic [31:0] slotAddr(input logic [31:0] ptr, input logic [31:0] mask,
                                           input int desc, input int pages,
                                           input logic [MAXP*PFN_W-1:0] pfns);
    logic [31:0] idx, base;
    int pg;
    idx = ptr & mask;
    pg = int'(idx) / PER;
    base = (pg < pages) ? {pfns[pg*PFN_W +: PFN_W], 12'h000} : 32'h0;
    return base + (idx % PER) * desc;
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R12 reset state
    for (int w = 0; w < 9; w++) begin
      shRead(4'(w), rd);
      chk("R12 shared word after reset", rd, 0);
    end
    chk("R12 reqReady", 32'(reqReady), 0);
    chk("R12 msgRoom", 32'(msgRoom), 0);
    chk("R12 cfgDone", 32'(cfgDone), 0);
    chk("R12 addresses", 32'(reqDescAddr | cmpDescAddr | msgDescAddr), 0);

    // R11 host write, unmapped read
    shWrite(4'd4, 32'h9);
    shRead(4'd4, rd);
    chk("R11 host write readback", rd, 32'h9);
    shWrite(4'd12, 32'hABCD);
    shRead(4'd12, rd);
    chk("R11 unmapped reads zero", rd, 0);

    // R3 pop before setup is ignored
    shWrite(4'd0, 32'd5);
    reqPop = 1'b1; tick(); reqPop = 1'b0;
    chk("R3 not ready before setup", 32'(reqReady), 0);
    chk("R3 null address before setup", reqDescAddr, 0);

    // R2 rejected data setups
    reqPageCnt = 8'd5; cmpPageCnt = 8'd2;
    cfgData = 1'b1; tick(); cfgData = 1'b0;
    chk("R2 too many pages done", 32'(cfgDone), 1);
    chk("R2 too many pages ok", 32'(cfgOk), 0);
    shRead(4'd2, rd);
    chk("R2 log2 untouched", rd, 0);
    reqPageCnt = 8'd3; cmpPageCnt = 8'd0;
    cfgData = 1'b1; tick(); cfgData = 1'b0;
    chk("R2 zero pages ok", 32'(cfgOk), 0);
    chk("R2 still not ready", 32'(reqReady), 0);

    // R1 accepted setup: req 3 pages x4 -> 11 -> 4 bits; cmp 2 pages x4 -> 7 -> 3 bits
    reqPageCnt = 8'd3; cmpPageCnt = 8'd2;
    cfgData = 1'b1; tick(); cfgData = 1'b0;
    chk("R1 setup ok", 32'(cfgOk), 1);
    shRead(4'd2, rd); chk("R1 req log2", rd, 4);
    shRead(4'd5, rd); chk("R1 cmp log2", rd, 3);
    shRead(4'd0, rd); chk("R1 req producer zeroed", rd, 0);
    shRead(4'd4, rd); chk("R1 cmp consumer zeroed", rd, 0);
    chk("R3 empty after setup", 32'(reqReady), 0);

    // R3 R4 R5 R9 table walk
    for (int v = 0; v < 5; v++) begin
      shWrite(4'd0, VEC[v][0]);
      reqPop = 1'b1;
      repeat (int'(VEC[v][1])) tick();
      reqPop = 1'b0;
      reqFlush = 1'b1; tick(); reqFlush = 1'b0;
      shRead(4'd1, rd);
      chk("R5 R9 consume pointer published", rd, VEC[v][2]);
      chk("R3 ready flag", 32'(reqReady), 32'(VEC[v][0] != VEC[v][2]));
      chk("R4 request address", reqDescAddr,
          (VEC[v][0] != VEC[v][2]) ? slotAddr(VEC[v][2], 32'd15, 128, 3, reqPfnList) : 32'h0);
    end

    // R4 index in a page slot beyond the count: pointer 28 -> idx 12 -> page 3 -> base 0
    shWrite(4'd0, 32'd40);
    reqPop = 1'b1; repeat (10) tick(); reqPop = 1'b0;
    chk("R4 unconfigured page gives zero base", reqDescAddr, 32'h0);
    reqPop = 1'b1; tick(); reqPop = 1'b0;
    chk("R4 slot one of zero-base page", reqDescAddr, 32'd128);

    // R2 reject after acceptance keeps state
    reqPageCnt = 8'd5;
    cfgData = 1'b1; tick(); cfgData = 1'b0;
    chk("R2 late reject ok", 32'(cfgOk), 0);
    chk("R2 address kept", reqDescAddr, 32'd128);
    reqPageCnt = 8'd3;

    // R6 completion: no overflow check
    cmpPop = 1'b1; repeat (10) tick(); cmpPop = 1'b0;
    cmpFlush = 1'b1; tick(); cmpFlush = 1'b0;
    shRead(4'd3, rd);
    chk("R6 R9 cmp fill published", rd, 10);
    chk("R6 cmp address", cmpDescAddr, slotAddr(32'd10, 32'd7, 32, 2, cmpPfnList));

    // R8 message setup
    msgPageCnt = 8'd3;
    cfgMsg = 1'b1; tick(); cfgMsg = 1'b0;
    chk("R8 msg too many pages", 32'(cfgOk), 0);
    chk("R7 no room before msg setup", 32'(msgRoom), 0);
    msgPageCnt = 8'd1;
    cfgMsg = 1'b1; tick(); cfgMsg = 1'b0;
    chk("R8 msg setup ok", 32'(cfgOk), 1);
    shRead(4'd8, rd); chk("R8 msg log2", rd, 2);
    chk("R7 room when empty", 32'(msgRoom), 1);

    // R7 room edges, mask 3
    shWrite(4'd6, 32'd4);
    chk("R7 full ring", 32'(msgRoom), 0);
    shWrite(4'd7, 32'd1);
    chk("R7 one consumed", 32'(msgRoom), 1);
    shWrite(4'd6, 32'd0);
    shWrite(4'd7, 32'hFFFF_FFFD);
    chk("R7 wrapped gap of three", 32'(msgRoom), 1);
    shWrite(4'd7, 32'hFFFF_FFFC);
    chk("R7 wrapped gap of four", 32'(msgRoom), 0);

    // R6 message pops ignore room, R11 block write wins
    msgPop = 1'b1; repeat (5) tick(); msgPop = 1'b0;
    chk("R6 msg address", msgDescAddr, 32'h77040);
    msgFlush = 1'b1; shWrEn = 1'b1; shAddr = 4'd6; shWrData = 32'h1234;
    tick();
    msgFlush = 1'b0; shWrEn = 1'b0;
    shRead(4'd6, rd);
    chk("R11 R9 block write wins", rd, 5);

    // R10 wipe
    wipe = 1'b1; tick(); wipe = 1'b0;
    chk("R10 reqReady cleared", 32'(reqReady), 0);
    chk("R10 addresses cleared", 32'(reqDescAddr | cmpDescAddr | msgDescAddr), 0);
    chk("R10 msgRoom cleared", 32'(msgRoom), 0);
    shRead(4'd2, rd);
    chk("R10 shared words kept", rd, 4);
    reqPop = 1'b1; tick(); reqPop = 1'b0;
    chk("R10 R3 pop ignored after wipe", reqDescAddr, 0);
    cfgMsg = 1'b1; tick(); cfgMsg = 1'b0;
    chk("R8 msg setup needs data rings", 32'(cfgOk), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule